// File: doc/BRIEF.md
# Brown-out Detector Control Logic

This block is the digital side of a supply-voltage monitor. An analog comparator reports whether the supply has fallen below a selectable threshold. The block brings that signal into the clock domain and holds the control fields that the analog circuit needs. It watches for the supply moving across the threshold in either direction, records any such event in a sticky flag, and then acts in one of two ways. It either requests an interrupt or requests a reset of the whole chip, depending on one control bit.

All software-visible state sits in a single 8-bit control/status register with one read/write port. The detector enable, the threshold select, the reset-or-interrupt select, the low-power mode bit and the low-voltage-reset enable only change when the protection logic raises a write permit. The crossing flag is cleared by writing 1 to it, and this works with or without the permit. The block also gates a low-voltage-reset trip input. That request stays masked until a settling time, given in microseconds and converted to clock cycles, has passed since the low-voltage-reset function was last enabled.

Top module: `bod_ctl`

## Requirements
- R1: After reset the register reads `{lvr_en=INIT_LVR_EN, status=0, lowpwr=0, flag=0, rst_sel=INIT_RST_SEL, level=00, en=INIT_EN}` in bits 7..0. With the defaults this is 8'h80. irq_o, chip_rst_req_o and lvr_rst_req_o are low.
- R2: A write that occurs while wr_permit_i is low leaves the protected fields unchanged. These are en (bit 0), level (bits 2:1), rst_sel (bit 3), lowpwr (bit 5) and lvr_en (bit 7).
- R3: A write that occurs while wr_permit_i is high loads the protected fields from the same bit positions of reg_wdata_i.
- R4: The status bit (bit 6) reads 1 only when the detector is enabled and the synchronized comparator reports the supply below threshold. It reads 0 whenever the detector is disabled.
- R5: While the detector is enabled, a change of the synchronized comparator value in either direction sets the flag (bit 4) two clocks after the first synchronizer stage captures it. A change while the detector is disabled does not set it.
- R6: Writing 1 to bit 4 clears the flag, with or without the permit. Writing 0 to bit 4 leaves it unchanged.
- R7: If a crossing and a clearing write occur in the same cycle, the flag ends up set.
- R8: chip_rst_req_o is high exactly when en=1, rst_sel=1 and status=1.
- R9: irq_o is high exactly when the flag is 1, en=1 and rst_sel=0.
- R10: lvr_rst_req_o stays low until SETTLE_US microseconds of clock cycles have passed with lvr_en=1. After that it follows the synchronized lvr_trip_i. Clearing lvr_en restarts the wait.
- R11: Writes to the status bit (bit 6) have no effect on it.
- R12: det_en_o, det_level_o, det_lowpwr_o and lvr_en_o always equal the en, level, lowpwr and lvr_en fields of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_below_i | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| lvr_trip_i | input | 1 | Asynchronous low-voltage detector output, 1 = trip |
| wr_permit_i | input | 1 | Protection logic allows writes to protected fields |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| det_en_o | output | 1 | Detector enable to the analog circuit |
| det_level_o | output | 2 | Threshold select to the analog circuit |
| det_lowpwr_o | output | 1 | Low-power mode to the analog circuit |
| lvr_en_o | output | 1 | Low-voltage-reset enable to the analog circuit |
| irq_o | output | 1 | Interrupt request |
| chip_rst_req_o | output | 1 | Chip reset request |
| lvr_rst_req_o | output | 1 | Low-voltage reset request after settling |

## Verification
The bench builds the block with CLK_FREQ_HZ = 125 MHz and SETTLE_US = 1. This shrinks the settling window to 125 cycles, so the masked phase, its expiry and its restart after lvr_en is toggled all fit into a short run. SYNC_STAGES stays at 2, which places the flag update exactly three edges after an input change. That timing lets the bench line up a crossing and a clearing write in the same cycle. The reset defaults are kept (detector off, interrupt mode, low-voltage reset on), so the table first shows protected writes being refused and then accepted.

// File: rtl/bod_ctl_pkg.sv
// Package: field layout and control-field type of the brown-out register.
// Assumes an 8-bit register whose bit positions are fixed by software.
package bod_ctl_pkg;
    localparam int REG_W      = 8;
    localparam int LEVEL_W    = 2;
    localparam int B_EN       = 0;
    localparam int B_LEVEL_LO = 1;
    localparam int B_RST_SEL  = 3;
    localparam int B_FLAG     = 4;
    localparam int B_LOWPWR   = 5;
    localparam int B_STATUS   = 6;
    localparam int B_LVR_EN   = 7;

    typedef struct packed {
        logic               lvr_en;
        logic               lowpwr;
        logic               rst_sel;
        logic [LEVEL_W-1:0] level;
        logic               en;
    } bod_ctrl_t;
endpackage

// File: rtl/bod_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed).
module bod_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the input one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_i;
                else
                    stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bod_xing_flag.sv
// Module: detects threshold crossings in both directions and keeps a
// sticky write-one-to-clear flag. Assumes level_i is already synchronous.
module bod_xing_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic level_i,
    input  logic clr_i,
    output logic flag_o
);
    logic prev_q;
    logic flag_q;
    logic set_w;

    // Purpose: remember the last synchronized comparator sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign set_w = arm_i && (level_i != prev_q);

    // Purpose: sticky flag, hardware set takes priority over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_w) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && clr_i) |=> flag_q);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_w) |=> !flag_q);
    a_r5_rise_needs_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(arm_i && (level_i != prev_q)));
endmodule

// File: rtl/bod_lvr_settle.sv
// Module: masks the low-voltage reset request until a settling count has
// elapsed since enable. Assumes SETTLE_CYCLES >= 1.
module bod_lvr_settle #(
    parameter int SETTLE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count enabled cycles up to the limit, restart when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)  cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready_o = en_i && (cnt_q == LIMIT);

    a_r10_off_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));
    a_r10_restart_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> !ready_o);
endmodule

// File: rtl/bod_ctl.sv
// Module: brown-out detector control/status register and request logic.
// Assumes cmp_below_i and lvr_trip_i are asynchronous; the permit input
// comes from the register protection logic; reset is synchronous.
module bod_ctl
    import bod_ctl_pkg::*;
#(
    parameter int         CLK_FREQ_HZ  = 50_000_000,
    parameter int         SETTLE_US    = 100,
    parameter int         SYNC_STAGES  = 2,
    parameter logic       INIT_EN      = 1'b0,
    parameter logic       INIT_RST_SEL = 1'b0,
    parameter logic       INIT_LVR_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_below_i,
    input  logic               lvr_trip_i,
    input  logic               wr_permit_i,
    input  logic               reg_we_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               det_en_o,
    output logic [LEVEL_W-1:0] det_level_o,
    output logic               det_lowpwr_o,
    output logic               lvr_en_o,
    output logic               irq_o,
    output logic               chip_rst_req_o,
    output logic               lvr_rst_req_o
);
    localparam int SETTLE_CYCLES_RAW = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;
    localparam int SETTLE_CYCLES = (SETTLE_CYCLES_RAW < 1) ? 1 : SETTLE_CYCLES_RAW;

    bod_ctrl_t  ctrl_q;
    logic [1:0] sync_w;
    logic       below_w;
    logic       trip_w;
    logic       status_w;
    logic       flag_w;
    logic       clr_w;
    logic       lvr_ready_w;

    bod_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lvr_trip_i, cmp_below_i}),
        .sync_o  (sync_w)
    );
    assign below_w = sync_w[0];
    assign trip_w  = sync_w[1];

    // Purpose: protected control fields, loaded only under write permit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.en      <= INIT_EN;
            ctrl_q.level   <= '0;
            ctrl_q.rst_sel <= INIT_RST_SEL;
            ctrl_q.lowpwr  <= 1'b0;
            ctrl_q.lvr_en  <= INIT_LVR_EN;
        end else if (reg_we_i && wr_permit_i) begin
            ctrl_q.en      <= reg_wdata_i[B_EN];
            ctrl_q.level   <= reg_wdata_i[B_LEVEL_LO +: LEVEL_W];
            ctrl_q.rst_sel <= reg_wdata_i[B_RST_SEL];
            ctrl_q.lowpwr  <= reg_wdata_i[B_LOWPWR];
            ctrl_q.lvr_en  <= reg_wdata_i[B_LVR_EN];
        end
    end

    assign clr_w = reg_we_i && reg_wdata_i[B_FLAG];

    bod_xing_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (ctrl_q.en),
        .level_i (below_w),
        .clr_i   (clr_w),
        .flag_o  (flag_w)
    );

    bod_lvr_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ctrl_q.lvr_en),
        .ready_o (lvr_ready_w)
    );

    assign status_w = ctrl_q.en && below_w;

    // Purpose: assemble the read view of the register.
    always_comb begin
        reg_rdata_o                            = '0;
        reg_rdata_o[B_EN]                      = ctrl_q.en;
        reg_rdata_o[B_LEVEL_LO +: LEVEL_W]     = ctrl_q.level;
        reg_rdata_o[B_RST_SEL]                 = ctrl_q.rst_sel;
        reg_rdata_o[B_FLAG]                    = flag_w;
        reg_rdata_o[B_LOWPWR]                  = ctrl_q.lowpwr;
        reg_rdata_o[B_STATUS]                  = status_w;
        reg_rdata_o[B_LVR_EN]                  = ctrl_q.lvr_en;
    end

    assign det_en_o       = ctrl_q.en;
    assign det_level_o    = ctrl_q.level;
    assign det_lowpwr_o   = ctrl_q.lowpwr;
    assign lvr_en_o       = ctrl_q.lvr_en;
    assign irq_o          = flag_w && ctrl_q.en && !ctrl_q.rst_sel;
    assign chip_rst_req_o = status_w && ctrl_q.rst_sel;
    assign lvr_rst_req_o  = lvr_ready_w && trip_w;

    a_r2_protected_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && wr_permit_i) |=> $stable(ctrl_q));
    a_r4_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en_o |-> !reg_rdata_o[B_STATUS]);
    a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && chip_rst_req_o));
    a_r8_rst_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req_o |-> (det_en_o && reg_rdata_o[B_RST_SEL]));
    a_r10_lvr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        lvr_rst_req_o |-> lvr_en_o);
endmodule

// File: tb/bod_ctl_test.sv
module bod_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_below = 1'b0;
    logic       lvr_trip = 1'b0;
    logic       permit = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       det_en, det_lowpwr, lvr_en, irq, chip_rst, lvr_req;
    logic [1:0] det_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bod_ctl #(.CLK_FREQ_HZ(125_000_000), .SETTLE_US(1), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_below_i(cmp_below), .lvr_trip_i(lvr_trip),
        .wr_permit_i(permit), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .det_en_o(det_en), .det_level_o(det_level),
        .det_lowpwr_o(det_lowpwr), .lvr_en_o(lvr_en), .irq_o(irq),
        .chip_rst_req_o(chip_rst), .lvr_rst_req_o(lvr_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // row: {permit, we, cmp, wdata, exp_rdata, exp_irq, exp_rst}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 8'h01, 8'h80, 1'b0, 1'b0}, // R2 refused write
        {1'b1, 1'b1, 1'b0, 8'h83, 8'h83, 1'b0, 1'b0}, // R3 accepted write
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hD3, 1'b1, 1'b0}, // R4 R5 R9 drop below
        {1'b0, 1'b1, 1'b1, 8'h10, 8'hC3, 1'b0, 1'b0}, // R6 clear without permit
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h93, 1'b1, 1'b0}, // R5 rise above
        {1'b1, 1'b1, 1'b0, 8'h9B, 8'h8B, 1'b0, 1'b0}, // R3 R6 reset mode + clear
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hDB, 1'b0, 1'b1}, // R8 reset request
        {1'b1, 1'b1, 1'b1, 8'h8A, 8'h9A, 1'b0, 1'b0}, // R4 R6 disable, write 0 keeps flag
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h9A, 1'b0, 1'b0}, // R5 no set while disabled
        {1'b1, 1'b1, 1'b0, 8'h7A, 8'h2A, 1'b0, 1'b0}  // R11 status write ignored
    };

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", rdata, 8'h80);
        chk("R1 irq/rst/lvr", {5'b0, irq, chip_rst, lvr_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {permit, we, cmp_below, wdata} = VEC[i][20:10];
            @(negedge clk);
            we = 1'b0;
            permit = 1'b0;
            repeat (3) @(negedge clk);
            chk($sformatf("R4/R5/R6 row %0d rdata", i), rdata, VEC[i][9:2]);
            chk($sformatf("R8/R9 row %0d irq,rst", i), {6'b0, irq, chip_rst}, {6'b0, VEC[i][1:0]});
            chk($sformatf("R12 row %0d fields", i), {det_en, det_level, det_lowpwr, lvr_en, 3'b0},
                {VEC[i][2], VEC[i][4:3], VEC[i][7], VEC[i][9], 3'b0});
        end

        // R7: crossing and clear in the same cycle
        permit = 1'b1; we = 1'b1; wdata = 8'h81;
        @(negedge clk);
        permit = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        cmp_below = 1'b1;
        @(negedge clk);
        @(negedge clk);
        we = 1'b1; wdata = 8'h10;
        @(negedge clk);
        we = 1'b0;
        chk("R7 set wins flag", {7'b0, rdata[4]}, 8'h01);
        chk("R7/R9 irq", {7'b0, irq}, 8'h01);
        we = 1'b1; wdata = 8'h10;
        @(negedge clk);
        we = 1'b0;
        chk("R6 later clear", {7'b0, rdata[4]}, 8'h00);

        // R10: settling mask after reset and after re-enable
        rst_n = 1'b0;
        lvr_trip = 1'b1;
        cmp_below = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk("R10 masked after reset", {7'b0, lvr_req}, 8'h00);
        repeat (35) @(negedge clk);
        chk("R10 active after settle", {7'b0, lvr_req}, 8'h01);
        permit = 1'b1; we = 1'b1; wdata = 8'h00;
        @(negedge clk);
        permit = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R10 off when disabled", {7'b0, lvr_req}, 8'h00);
        permit = 1'b1; we = 1'b1; wdata = 8'h80;
        @(negedge clk);
        permit = 1'b0; we = 1'b0;
        repeat (50) @(negedge clk);
        chk("R10 masked after re-enable", {7'b0, lvr_req}, 8'h00);
        repeat (90) @(negedge clk);
        chk("R10 active after re-settle", {7'b0, lvr_req}, 8'h01);
        lvr_trip = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 follows trip", {7'b0, lvr_req}, 8'h00);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule